// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Bank

This block keeps a 2048-byte bank of counters that requesters update atomically. One request is taken per cycle through a valid/ready handshake. It names a byte address, an operand size of 8, 16, 32 or 64 bits, and a flavour, load-style or store-style.

A load-style request adds a signed 22-bit increment, carried in the upper bits of its address, to the addressed counter. A store-style request carries a data word. One address bit chooses whether that word is added to the counter or written over it.

Every accepted request produces one registered response. The response holds the counter value from before the update, or an error flag if the byte address does not suit the operand size. The bank is stored as 64-bit words in little-endian order. A sub-word operation reads the word, extracts the lane, computes the new value and merges it back, all in a single cycle. The next request therefore always sees the previous result.

Top module: `fetch_add_bank`

## Requirements
- R1: After reset every counter reads zero, `rsp_valid` is low and `req_ready` is high.
- R2: A load-style request (`req_store`=0) sign-extends `req_addr[35:14]` to the operand size and adds it to the counter. The response returns the value the counter held before the add.
- R3: A store-style request with `req_addr[13]`=0 adds the low operand-size bits of `req_data` to the counter and returns the prior value.
- R4: A store-style request with `req_addr[13]`=1 overwrites the counter with the low operand-size bits of `req_data` and returns the prior value.
- R5: `req_size` selects the operand width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Response data is the prior value zero-extended to 64 bits.
- R6: Results wrap modulo 2^width with no saturation.
- R7: `req_addr[10:0]` is a byte address; bits 10:3 pick a 64-bit word and bits 2:0 a byte lane, with byte 0 the least significant. A sub-word update changes only the bytes it targets.
- R8: A byte address that is not a multiple of the operand size in bytes sets `rsp_err`, returns zero data and leaves the bank unchanged. A well-aligned request has `rsp_err` low.
- R9: Requests accepted in consecutive cycles on the same counter each see the previous result, so no update is lost.
- R10: A response is held with stable data while `rsp_ready` is low. During that time `req_ready` is low and no new request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_store | input | 1 | 1 = store-style, 0 = load-style |
| req_addr | input | 36 | Increment [35:14], store mode [13], byte address [10:0] |
| req_size | input | 2 | Operand width code |
| req_data | input | 64 | Store operand |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_data | output | 64 | Prior counter value, zero-extended |
| rsp_err | output | 1 | Misaligned request |

## Verification
The assertions assume that the requester keeps `rsp_ready` and the request fields at known values after reset. They also assume that a stalled response is eventually taken. The bench drives every input from a negative clock edge and never leaves one unknown. Random addresses are confined to a 64-byte window so that the four sizes overlap and collide on shared words. A small fraction of the requests is deliberately misaligned to exercise the error path.

// File: rtl/fetch_add_bank.sv
module fetch_add_bank #(
  parameter int BYTES   = 2048,
  parameter int INC_LSB = 14,
  parameter int INC_W   = 22,
  parameter int MODE_BIT = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_store,
  input  logic [35:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic [63:0] req_data,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [63:0] rsp_data,
  output logic        rsp_err
);
  localparam int ABITS = $clog2(BYTES);
  localparam int WORDS = BYTES / 8;
  localparam int WBITS = ABITS - 3;
  localparam int INC_MSB = INC_LSB + INC_W - 1;

  logic [63:0] mem [WORDS];
  logic [1:0]  rsp_size;

  wire             fire = req_valid && req_ready;
  wire [WBITS-1:0] idx  = req_addr[ABITS-1:3];
  wire [2:0]       lane = req_addr[2:0];
  wire [5:0]       shamt = {lane, 3'b000};

  logic        misalign;
  logic [63:0] mask;
  always_comb begin
    case (req_size)
      2'd0: begin misalign = 1'b0;       mask = 64'h0000_0000_0000_00FF; end
      2'd1: begin misalign = lane[0];    mask = 64'h0000_0000_0000_FFFF; end
      2'd2: begin misalign = |lane[1:0]; mask = 64'h0000_0000_FFFF_FFFF; end
      default: begin misalign = |lane;   mask = '1; end
    endcase
  end

  wire [63:0] cur     = mem[idx];
  wire [63:0] old     = (cur >> shamt) & mask;
  wire [63:0] inc     = {{(64-INC_W){req_addr[INC_MSB]}}, req_addr[INC_MSB:INC_LSB]};
  wire        overwr  = req_store && req_addr[MODE_BIT];
  wire [63:0] operand = req_store ? req_data : inc;
  wire [63:0] nv      = (overwr ? operand : old + operand) & mask;
  wire [63:0] merged  = (cur & ~(mask << shamt)) | (nv << shamt);

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (fire && !misalign) begin
      mem[idx] <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      rsp_size  <= 2'd0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= misalign ? 64'd0 : old;
      rsp_err   <= misalign;
      rsp_size  <= req_size;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_data == 64'd0);

  // R8
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid && (rsp_err == $past(misalign)));

  // R5
  byte_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_size == 2'd0 |-> rsp_data[63:8] == 56'd0);

  // R5
  half_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_size == 2'd1 |-> rsp_data[63:16] == 48'd0);
endmodule

// File: tb/fetch_add_bank_test.sv
`timescale 1ns/1ps
module fetch_add_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, rsp_ready = 1'b1;
  logic [35:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_data = '0;
  wire         req_ready, rsp_valid, rsp_err;
  wire  [63:0] rsp_data;

  fetch_add_bank uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_addr(req_addr), .req_size(req_size), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err));

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  logic [7:0] mb [2048];
  bit pend = 0;
  logic [63:0] exp_data;
  bit exp_err;
  string ptag;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] mka(logic [21:0] inc, bit mode, logic [10:0] b);
    return {inc, mode, 2'b00, b};
  endfunction

  task automatic model(bit st, logic [35:0] a, logic [63:0] d, logic [1:0] sz,
                       output logic [63:0] rd, output bit er);
    int n = 1 << sz;
    int b = int'(a[10:0]);
    logic [63:0] old, op, nv, mk;
    er = (b % n) != 0;
    rd = '0;
    if (er) return;
    old = '0;
    for (int i = 0; i < n; i++) old = old | (64'(mb[b+i]) << (8*i));
    mk = (sz == 2'd3) ? '1 : ((64'd1 << (8*n)) - 64'd1);
    op = st ? d : {{42{a[35]}}, a[35:14]};
    nv = ((st && a[13]) ? op : old + op) & mk;
    for (int i = 0; i < n; i++) mb[b+i] = nv[8*i +: 8];
    rd = old;
  endtask

  task automatic step(bit v, bit st, logic [35:0] a, logic [63:0] d, logic [1:0] sz, string tag);
    @(negedge clk);
    if (pend)
      chk(rsp_valid && rsp_err == exp_err && rsp_data == exp_data, ptag,
          {rsp_err, rsp_data[62:0]}, {exp_err, exp_data[62:0]});
    req_valid = v; req_store = st; req_addr = a; req_data = d; req_size = sz;
    if (v) model(st, a, d, sz, exp_data, exp_err);
    pend = v;
    ptag = tag;
  endtask

  initial begin
    #(4.0 * 200000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    for (int i = 0; i < 2048; i++) mb[i] = 8'h00;
    seed = $urandom(32'd20240607);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!rsp_valid && req_ready, "R1", {62'd0, rsp_valid, req_ready}, 64'd1);
    step(1, 0, mka(22'd0, 0, 11'h7F8), 0, 2'd3, "R1");
    step(1, 0, mka(22'd0, 0, 11'h000), 0, 2'd3, "R1");

    // R2 load add, negative increment sign-extended
    step(1, 0, mka(22'h3FFFFF, 0, 11'h010), 0, 2'd1, "R2");
    step(1, 0, mka(22'd0, 0, 11'h010), 0, 2'd1, "R2");
    step(1, 0, mka(22'h1FFFFF, 0, 11'h020), 0, 2'd2, "R2");
    step(1, 0, mka(22'd0, 0, 11'h020), 0, 2'd2, "R2");
    // R3 / R4 store add and overwrite
    step(1, 1, mka(22'd0, 1, 11'h030), 64'hDEAD_BEEF_0000_0001, 2'd3, "R4");
    step(1, 1, mka(22'd0, 0, 11'h030), 64'h0000_0000_0000_0010, 2'd3, "R3");
    step(1, 0, mka(22'd0, 0, 11'h030), 0, 2'd3, "R3");
    // R6 wrap on 8-bit and 64-bit
    step(1, 1, mka(22'd0, 1, 11'h041), 64'hFF, 2'd0, "R6");
    step(1, 0, mka(22'd1, 0, 11'h041), 0, 2'd0, "R6");
    step(1, 0, mka(22'd0, 0, 11'h041), 0, 2'd0, "R6");
    step(1, 1, mka(22'd0, 1, 11'h048), '1, 2'd3, "R6");
    step(1, 0, mka(22'd1, 0, 11'h048), 0, 2'd3, "R6");
    step(1, 0, mka(22'd0, 0, 11'h048), 0, 2'd3, "R6");
    // R7 lane placement, neighbours untouched
    step(1, 1, mka(22'd0, 1, 11'h100), 64'h0102_0304_0506_0708, 2'd3, "R7");
    step(1, 1, mka(22'd0, 0, 11'h103), 64'hFF, 2'd0, "R7");
    step(1, 1, mka(22'd0, 1, 11'h106), 64'hAAAA, 2'd1, "R7");
    step(1, 0, mka(22'd0, 0, 11'h100), 0, 2'd3, "R7");
    // R5 upper response bits zero for a narrow read of a full word
    step(1, 0, mka(22'd0, 0, 11'h104), 0, 2'd2, "R5");
    // R8 misaligned then confirm no change
    step(1, 1, mka(22'd0, 1, 11'h101), 64'h1234, 2'd1, "R8");
    step(1, 0, mka(22'd5, 0, 11'h104), 0, 2'd3, "R8");
    step(1, 0, mka(22'd7, 0, 11'h102), 0, 2'd2, "R8");
    step(1, 0, mka(22'd0, 0, 11'h100), 0, 2'd3, "R8");
    // R9 back-to-back on one counter
    for (int i = 0; i < 6; i++) step(1, 0, mka(22'd3, 0, 11'h200), 0, 2'd2, "R9");
    step(1, 1, mka(22'd0, 0, 11'h200), 64'd100, 2'd2, "R9");
    step(1, 0, mka(22'd0, 0, 11'h200), 0, 2'd2, "R9");
    step(0, 0, '0, 0, 2'd0, "");

    // R10 stall
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_store = 1'b0; req_addr = mka(22'd5, 0, 11'h208); req_size = 2'd3;
    model(0, req_addr, 0, 2'd3, exp_data, exp_err);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && !req_ready && rsp_data == exp_data, "R10", rsp_data, exp_data);
    @(negedge clk);
    chk(rsp_valid && !req_ready && rsp_data == exp_data, "R10", rsp_data, exp_data);
    req_valid = 1'b1; req_addr = mka(22'd9, 0, 11'h208);
    @(negedge clk);
    chk(rsp_valid && rsp_data == exp_data, "R10", rsp_data, exp_data);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid, "R10", {63'd0, rsp_valid}, 64'd0);
    step(1, 0, mka(22'd0, 0, 11'h208), 0, 2'd3, "R10");

    // random mix
    for (int k = 0; k < 500; k++) begin
      logic [1:0] sz;
      int n, b;
      bit st, md;
      string tg;
      sz = 2'($urandom % 4);
      n = 1 << sz;
      b = int'($urandom % 64) & ~(n - 1);
      if (sz != 0 && ($urandom % 16) == 0) b = b | 1;
      st = 1'($urandom % 2);
      md = 1'($urandom % 2);
      if (b % n != 0) tg = "R8";
      else if (st && md) tg = "R4";
      else if (st) tg = "R3";
      else tg = "R2";
      step(1, st, mka(22'($urandom), md, 11'(b)), {$urandom, $urandom}, sz, tg);
    end
    step(0, 0, '0, 0, 2'd0, "");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule